// File: doc/BRIEF.md
# Serial Bus Hold Pause Controller

This block sits beside the receive and transmit logic of a serial slave port and decides when that logic may see serial clock edges and drive its data output. It watches the active-low select, the serial clock and an active-low pause pin. When the bus master lowers the pause pin mid-transfer, the block freezes the transfer: clock edges stop reaching the shift logic and the output driver is released. When the pause pin returns high, the transfer continues from the bit where it stopped.

Entry into and exit from the pause are qualified by the clock level. A change of the pause pin while the clock is low acts at once. A change while the clock is high waits for the next falling clock edge. A pause request that is withdrawn before that edge is dropped and never asserts the pause. Raising select at any time, including during a pause, aborts the transfer and clears its position.

All three pins are brought into the system clock domain through a synchronizer of configurable depth. A small bit-position counter shows the pause-and-resume behaviour at the block's edge: it counts accepted rising clock edges.

Top module: `hold_pause_ctrl`

## Requirements
- R1: While `cs_n` is high, `hold_active` stays low, edges on `hold_n` do not start a pause, and `sclk` edges do not produce `sample_en` or advance `bit_pos`.
- R2: With `cs_n` low and `sclk` low, a falling edge of `hold_n` raises `hold_active`.
- R3: With `cs_n` low and `sclk` high, a falling edge of `hold_n` leaves `hold_active` low until the next falling edge of `sclk`, which then raises it; that falling edge produces no `shift_en` pulse.
- R4: During a pause, a rising edge of `hold_n` with `sclk` low lowers `hold_active` at once; with `sclk` high, `hold_active` stays high until the next falling edge of `sclk`.
- R5: While `hold_active` is high, `sample_en`, `shift_en` and `out_en` are all low, whatever `sclk` and `tx_drive` do.
- R6: A rising edge of `cs_n` gives exactly one `xact_clear` pulse, sets `bit_pos` to 0 and ends any pause.
- R7: `bit_pos` advances by one for each accepted rising `sclk` edge, keeps its value through a pause and continues from that value after release.
- R8: A pause request made while `sclk` is high and withdrawn (with `hold_n` back high) before the next falling `sclk` edge never raises `hold_active`, and that falling edge is an ordinary shift edge.
- R9: `bit_pos` is `CNT_W` bits wide and wraps from its all-ones value to 0.
- R10: `out_en` equals `tx_drive` while `cs_n` is low and no pause is active, and is low while `cs_n` is high.
- R11: After reset, `hold_active`, `sample_en`, `shift_en`, `out_en` and `xact_clear` are low and `bit_pos` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the bus |
| sclk | input | 1 | Serial clock from the bus |
| hold_n | input | 1 | Active-low pause request from the bus |
| tx_drive | input | 1 | Request from the transmit logic to drive the data line |
| hold_active | output | 1 | High while the transfer is paused |
| sample_en | output | 1 | One-cycle pulse for an accepted rising serial clock edge |
| shift_en | output | 1 | One-cycle pulse for an accepted falling serial clock edge |
| out_en | output | 1 | Output driver enable; low means high impedance |
| xact_clear | output | 1 | One-cycle pulse when select is released |
| bit_pos | output | CNT_W | Count of accepted rising edges in the current transfer |

## Verification
The bench builds the block with `SYNC_STAGES` = 2 and `CNT_W` = 4. Every pin change therefore settles within a few system clocks, so the bench can hold each level for a fixed short interval. The 4-bit counter wraps after only sixteen serial clocks, which puts the R9 boundary within reach of a single directed scenario. Deferred entry, deferred exit and the cancelled request are each driven with the serial clock held high around the pause-pin edge, and ordinary entry and exit with it held low.

// File: rtl/hold_pause_pkg.sv
package hold_pause_pkg;

    // Pause tracking states
    typedef enum logic [1:0] {
        HS_RUN        = 2'd0,
        HS_ENTER_WAIT = 2'd1,
        HS_PAUSED     = 2'd2,
        HS_EXIT_WAIT  = 2'd3
    } hold_state_e;

    // Synchronized pin levels and the edges seen on them
    typedef struct packed {
        logic sel;        // select asserted (cs_n low)
        logic sclk_lvl;   // synchronized serial clock level
        logic hold_lvl;   // synchronized hold_n level
        logic sclk_rise;
        logic sclk_fall;
        logic hold_fall;
        logic hold_rise;
        logic desel_evt;  // cs_n went high
    } pin_evt_t;

    // Lane order inside the synchronizer vector
    localparam int LANE_CS   = 0;
    localparam int LANE_SCLK = 1;
    localparam int LANE_HOLD = 2;
    localparam int N_LANES   = 3;

    // Idle levels of the pins: select off, clock low, no pause
    localparam logic [N_LANES-1:0] PIN_IDLE = 3'b101;

    function automatic logic is_paused(hold_state_e s);
        return (s == HS_PAUSED) || (s == HS_EXIT_WAIT);
    endfunction

    function automatic logic edges_pass(hold_state_e s);
        return (s == HS_RUN) || (s == HS_ENTER_WAIT);
    endfunction

endpackage

// File: rtl/hp_pin_sync.sv
module hp_pin_sync
    import hold_pause_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sclk,
    input  logic     hold_n,
    output pin_evt_t evt
);

    logic [N_LANES-1:0] raw;
    logic [N_LANES-1:0] lvl;
    logic [N_LANES-1:0] prev;

    assign raw[LANE_CS]   = cs_n;
    assign raw[LANE_SCLK] = sclk;
    assign raw[LANE_HOLD] = hold_n;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [STAGES:0] sh;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh <= {(STAGES+1){PIN_IDLE[g]}};
            end else begin
                sh <= {sh[STAGES-1:0], raw[g]};
            end
        end

        assign lvl[g]  = sh[STAGES-1];
        assign prev[g] = sh[STAGES];
    end

    always_comb begin
        evt.sel       = ~lvl[LANE_CS];
        evt.sclk_lvl  = lvl[LANE_SCLK];
        evt.hold_lvl  = lvl[LANE_HOLD];
        evt.sclk_rise =  lvl[LANE_SCLK] & ~prev[LANE_SCLK];
        evt.sclk_fall = ~lvl[LANE_SCLK] &  prev[LANE_SCLK];
        evt.hold_fall = ~lvl[LANE_HOLD] &  prev[LANE_HOLD];
        evt.hold_rise =  lvl[LANE_HOLD] & ~prev[LANE_HOLD];
        evt.desel_evt =  lvl[LANE_CS]   & ~prev[LANE_CS];
    end

endmodule

// File: rtl/hp_hold_fsm.sv
module hp_hold_fsm
    import hold_pause_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pin_evt_t    evt,
    output hold_state_e state,
    output logic        paused
);

    hold_state_e nxt;

    always_comb begin
        nxt = state;
        if (!evt.sel) begin
            nxt = HS_RUN;
        end else begin
            case (state)
                HS_RUN: begin
                    if (evt.hold_fall) begin
                        nxt = evt.sclk_lvl ? HS_ENTER_WAIT : HS_PAUSED;
                    end
                end
                HS_ENTER_WAIT: begin
                    // withdrawal wins over the deferred activation edge
                    if (evt.hold_rise) begin
                        nxt = HS_RUN;
                    end else if (evt.sclk_fall) begin
                        nxt = HS_PAUSED;
                    end
                end
                HS_PAUSED: begin
                    if (evt.hold_rise) begin
                        nxt = evt.sclk_lvl ? HS_EXIT_WAIT : HS_RUN;
                    end
                end
                HS_EXIT_WAIT: begin
                    if (evt.hold_fall) begin
                        nxt = HS_PAUSED;
                    end else if (evt.sclk_fall) begin
                        nxt = HS_RUN;
                    end
                end
                default: nxt = HS_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_RUN;
        end else begin
            state <= nxt;
        end
    end

    assign paused = is_paused(state);

endmodule

// File: rtl/hp_bit_tracker.sv
module hp_bit_tracker #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/hold_pause_ctrl.sv
module hold_pause_ctrl
    import hold_pause_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             hold_n,
    input  logic             tx_drive,
    output logic             hold_active,
    output logic             sample_en,
    output logic             shift_en,
    output logic             out_en,
    output logic             xact_clear,
    output logic [CNT_W-1:0] bit_pos
);

    pin_evt_t    evt;
    hold_state_e st;
    logic        paused;
    logic        sel_s;
    logic        sclk_s;
    logic        hold_s;

    hp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .hold_n (hold_n),
        .evt    (evt)
    );

    hp_hold_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .state  (st),
        .paused (paused)
    );

    assign sel_s  = evt.sel;
    assign sclk_s = evt.sclk_lvl;
    assign hold_s = evt.hold_lvl;

    assign hold_active = paused;
    assign sample_en   = sel_s && evt.sclk_rise && edges_pass(st);
    assign shift_en    = sel_s && evt.sclk_fall && (st == HS_RUN) && !evt.hold_fall;
    assign out_en      = tx_drive && sel_s && !paused;
    assign xact_clear  = evt.desel_evt;

    hp_bit_tracker #(.CNT_W(CNT_W)) u_pos (
        .clk   (clk),
        .rst   (rst),
        .clear (!sel_s),
        .step  (sample_en),
        .count (bit_pos)
    );

endmodule

// File: rtl/hold_pause_chk.sv
module hold_pause_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_s,
    input logic             sclk_s,
    input logic             hold_s,
    input logic             hold_active,
    input logic             sample_en,
    input logic             shift_en,
    input logic             out_en,
    input logic             xact_clear,
    input logic [CNT_W-1:0] bit_pos
);

    // R1
    desel_no_pause_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_s |=> !hold_active);

    // R2
    pause_entry_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_active) |-> (!$past(sclk_s) && !$past(hold_s)));

    // R4
    pause_exit_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_active) |-> (!$past(sclk_s) || !$past(sel_s)));

    // R5
    paused_no_edges_chk: assert property (@(posedge clk) disable iff (rst)
        hold_active |-> (!sample_en && !shift_en && !out_en));

    // R6
    clear_zeroes_pos_chk: assert property (@(posedge clk) disable iff (rst)
        xact_clear |=> (bit_pos == '0));

    // R7
    paused_pos_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_active && !xact_clear) |=> $stable(bit_pos));

endmodule

bind hold_pause_ctrl hold_pause_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sel_s       (sel_s),
    .sclk_s      (sclk_s),
    .hold_s      (hold_s),
    .hold_active (hold_active),
    .sample_en   (sample_en),
    .shift_en    (shift_en),
    .out_en      (out_en),
    .xact_clear  (xact_clear),
    .bit_pos     (bit_pos)
);

// File: tb/sim_hold_pause_ctrl.sv
module sim_hold_pause_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int SETTLE     = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cs_n = 1'b1;
    logic             sclk = 1'b0;
    logic             hold_n = 1'b1;
    logic             tx_drive = 1'b1;
    logic             hold_active;
    logic             sample_en;
    logic             shift_en;
    logic             out_en;
    logic             xact_clear;
    logic [CNT_W-1:0] bit_pos;

    int checks = 0;
    int fails  = 0;
    int n_samp = 0;
    int n_shift = 0;
    int n_clear = 0;
    int n_held = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hold_pause_ctrl #(.SYNC_STAGES(2), .CNT_W(CNT_W)) u0 (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .hold_n      (hold_n),
        .tx_drive    (tx_drive),
        .hold_active (hold_active),
        .sample_en   (sample_en),
        .shift_en    (shift_en),
        .out_en      (out_en),
        .xact_clear  (xact_clear),
        .bit_pos     (bit_pos)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (sample_en)   n_samp++;
            if (shift_en)    n_shift++;
            if (xact_clear)  n_clear++;
            if (hold_active) n_held++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic set_sclk(input logic v);
        sclk = v;
        settle();
    endtask

    task automatic set_hold(input logic v);
        hold_n = v;
        settle();
    endtask

    task automatic set_cs(input logic v);
        cs_n = v;
        settle();
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            set_sclk(1'b1);
            set_sclk(1'b0);
        end
    endtask

    task automatic t_reset();
        chk("R11 hold_active", int'(hold_active), 0);
        chk("R11 bit_pos", int'(bit_pos), 0);
        chk("R11 sample_en", int'(sample_en), 0);
        chk("R11 xact_clear", int'(xact_clear), 0);
        chk("R10 out_en deselected", int'(out_en), 0);
    endtask

    task automatic t_count();
        int s0, f0;
        set_cs(1'b0);
        chk("R10 out_en follows tx_drive", int'(out_en), 1);
        s0 = n_samp; f0 = n_shift;
        pulses(5);
        chk("R7 bit_pos after 5", int'(bit_pos), 5);
        chk("R7 sample pulses", n_samp - s0, 5);
        chk("R7 shift pulses", n_shift - f0, 5);
    endtask

    task automatic t_pause_low_clk();
        int s0, f0;
        set_hold(1'b0);
        chk("R2 hold_active", int'(hold_active), 1);
        chk("R5 out_en during pause", int'(out_en), 0);
        s0 = n_samp; f0 = n_shift;
        pulses(3);
        chk("R5 no sample during pause", n_samp - s0, 0);
        chk("R5 no shift during pause", n_shift - f0, 0);
        chk("R7 bit_pos frozen", int'(bit_pos), 5);
        set_hold(1'b1);
        chk("R4 immediate release", int'(hold_active), 0);
        pulses(1);
        chk("R7 resume position", int'(bit_pos), 6);
    endtask

    task automatic t_pause_high_clk();
        int f0;
        set_sclk(1'b1);
        set_hold(1'b0);
        chk("R3 entry deferred", int'(hold_active), 0);
        f0 = n_shift;
        set_sclk(1'b0);
        chk("R3 entry on falling sclk", int'(hold_active), 1);
        chk("R3 no shift on entry edge", n_shift - f0, 0);
        set_sclk(1'b1);
        set_hold(1'b1);
        chk("R4 exit deferred", int'(hold_active), 1);
        set_sclk(1'b0);
        chk("R4 exit on falling sclk", int'(hold_active), 0);
        chk("R7 position held", int'(bit_pos), 7);
        pulses(1);
        chk("R7 resume after deferred exit", int'(bit_pos), 8);
    endtask

    task automatic t_cancel();
        int h0, f0;
        set_sclk(1'b1);
        h0 = n_held;
        set_hold(1'b0);
        set_hold(1'b1);
        f0 = n_shift;
        set_sclk(1'b0);
        chk("R8 cancelled request never pauses", n_held - h0, 0);
        chk("R8 falling edge still shifts", n_shift - f0, 1);
        chk("R8 bit_pos", int'(bit_pos), 9);
    endtask

    task automatic t_abort();
        int c0;
        set_hold(1'b0);
        chk("R2 paused before abort", int'(hold_active), 1);
        c0 = n_clear;
        set_cs(1'b1);
        chk("R6 pause ended", int'(hold_active), 0);
        chk("R6 bit_pos cleared", int'(bit_pos), 0);
        chk("R6 one clear pulse", n_clear - c0, 1);
        set_hold(1'b1);
    endtask

    task automatic t_deselected();
        int s0;
        set_hold(1'b0);
        chk("R1 no pause while deselected", int'(hold_active), 0);
        s0 = n_samp;
        pulses(2);
        chk("R1 no sample while deselected", n_samp - s0, 0);
        chk("R1 bit_pos idle", int'(bit_pos), 0);
        set_hold(1'b1);
        set_cs(1'b0);
        chk("R1 no pause after select", int'(hold_active), 0);
    endtask

    task automatic t_wrap();
        int s0;
        s0 = n_samp;
        pulses(16);
        chk("R9 wrap to zero", int'(bit_pos), 0);
        chk("R9 sample pulses", n_samp - s0, 16);
        pulses(3);
        chk("R9 after wrap", int'(bit_pos), 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        t_count();
        t_pause_low_clk();
        t_pause_high_clk();
        t_cancel();
        t_abort();
        t_deselected();
        t_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule